// File: doc/BRIEF.md
# PCI Target Address Phase Decoder

This block sits behind one target on a 32-bit multiplexed PCI-style bus. It watches for the first clock of each transaction, when the shared AD lines carry an address and the command lines carry the bus command. In that clock it captures both, sorts the command into one of four cycle classes, and compares the address against two programmable windows. One window is for I/O space and one is for memory space. When the address falls inside the enabled window for its class, the block claims the transaction one clock later.

While it owns a transaction, the block drives a local memory port. The port carries an address, a read strobe and a write strobe for every completed data phase. For a memory burst the local address steps forward by one dword for each completed phase, so only the single address cycle is needed on the bus. For I/O the byte address stays fixed. A memory cycle that asks for a burst order other than linear increment is served for one data phase only, with a stop request raised.

Address decoding on the bus is distributed, so the block decides for itself whether to respond. Configuration and special cycles are never claimed here.

Top module: `pci_tgt_addr_dec`

## Requirements
- R1: During and right after reset, claim_o, stop_o, loc_rd_o and loc_wr_o are low and cyc_kind_o is 0.
- R2: The command is classified with the following kind codes on cyc_kind_o:
  - 1 (I/O) for commands 0010 and 0011.
  - 2 (memory) for 0110, 0111, 1100, 1110 and 1111.
  - 3 (configuration) for 1010 and 1011.
  - 0 (special) for every other command.
  - The code is valid from the clock after the address cycle and is held until the next address cycle.
- R3: An address cycle is a clock in which frame_i is high after a clock in which it was low, with the block idle. AD and command are captured only there. Values on ad_i and cmd_i in data phases do not change loc_addr_o.
- R4: An I/O command is claimed when io_en_i is 1 and ((ad ^ io_base_i) & io_mask_i) is zero over all 32 bits. loc_addr_o then holds the exact captured byte address for the whole transaction.
- R5: A memory command is claimed when mem_en_i is 1 and ((ad ^ mem_base_i) & mem_mask_i) is zero over bits 31..2; bits 1..0 take no part in the compare. The first local address is the captured address with bits 1..0 cleared.
- R6: Configuration and special commands are never claimed, whatever the address and window settings.
- R7: claim_o rises in the clock after the address cycle and stays high until the transaction ends.
- R8: A data phase completes on a clock where claim_o, irdy_i and trdy_i are all high. In that clock loc_wr_o is high if command bit 0 is 1, and loc_rd_o is high if it is 0. At no other time is either strobe high.
- R9: In a claimed memory transaction, loc_addr_o advances by 4, wrapping modulo 2^32, after each completed data phase and holds otherwise.
- R10: A completed data phase with frame_i low ends the transaction: claim_o is low in the following clock.
- R11: A claimed memory command whose captured bits 1..0 are not 00 raises stop_o together with claim_o. After its first completed data phase, claim_o and stop_o fall even if frame_i is still high, and no further strobes occur in that transaction.
- R12: An unclaimed transaction produces no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ad_i | input | 32 | Multiplexed address/data lines |
| cmd_i | input | 4 | Bus command, sampled in the address cycle |
| frame_i | input | 1 | Transaction active (high = asserted) |
| irdy_i | input | 1 | Initiator ready (high = ready) |
| trdy_i | input | 1 | Local target ready (high = ready) |
| mem_en_i | input | 1 | Memory window enable |
| mem_base_i | input | 32 | Memory window base |
| mem_mask_i | input | 32 | Memory window compare mask (1 = compared bit) |
| io_en_i | input | 1 | I/O window enable |
| io_base_i | input | 32 | I/O window base |
| io_mask_i | input | 32 | I/O window compare mask (1 = compared bit) |
| claim_o | output | 1 | Transaction claimed by this target |
| stop_o | output | 1 | Stop request for an unsupported burst order |
| cyc_kind_o | output | 2 | Class of the last captured command |
| loc_addr_o | output | 32 | Local port address |
| loc_rd_o | output | 1 | Local read strobe for a completed phase |
| loc_wr_o | output | 1 | Local write strobe for a completed phase |

## Verification
The two functions that share a clock are the address advance of a completed data phase and the end of the transaction. In the last phase of a burst, or the first phase of an unsupported one, the counter steps and the claim is released on the same edge. The bench provokes this with random burst lengths and random ready waits, and keeps frame_i high past the stop on unsupported bursts. The bench judges it two ways. The strobe and address must be right in the closing phase, and claim_o must be low in the next clock with no stray strobe after it.

// File: rtl/pci_tad_pkg.sv
package pci_tad_pkg;
  localparam int AD_W     = 32;
  localparam int CMD_W    = 4;
  localparam int DW_BYTES = 4;
  localparam int DW_LSB   = $clog2(DW_BYTES);

  typedef enum logic [1:0] {
    KIND_SPECIAL = 2'd0,
    KIND_IO      = 2'd1,
    KIND_MEM     = 2'd2,
    KIND_CFG     = 2'd3
  } cyc_kind_e;

  // sort a bus command into its cycle class
  function automatic cyc_kind_e classify(input logic [CMD_W-1:0] cmd);
    cyc_kind_e k;
    case (cmd)
      4'b0010, 4'b0011:                         k = KIND_IO;
      4'b0110, 4'b0111, 4'b1100, 4'b1110,
      4'b1111:                                  k = KIND_MEM;
      4'b1010, 4'b1011:                         k = KIND_CFG;
      default:                                  k = KIND_SPECIAL;
    endcase
    return k;
  endfunction

  // window compare: every bit selected by mask & keep must match base
  function automatic logic win_hit(input logic [AD_W-1:0] addr,
                                   input logic [AD_W-1:0] base,
                                   input logic [AD_W-1:0] mask,
                                   input logic [AD_W-1:0] keep);
    return ((addr ^ base) & mask & keep) == '0;
  endfunction

  // next dword address of a linear burst
  function automatic logic [AD_W-1:0] burst_next(input logic [AD_W-1:0] a);
    return a + AD_W'(DW_BYTES);
  endfunction

  // first local address: dword aligned for memory, byte exact otherwise
  function automatic logic [AD_W-1:0] first_addr(input logic [AD_W-1:0] a,
                                                 input logic dword_only);
    logic [AD_W-1:0] r;
    r = a;
    if (dword_only) r[DW_LSB-1:0] = '0;
    return r;
  endfunction
endpackage

// File: rtl/pci_tad_cmd_dec.sv
module pci_tad_cmd_dec
  import pci_tad_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_i,
  output cyc_kind_e        kind_o,
  output logic             is_write_o
);
  assign kind_o     = classify(cmd_i);
  assign is_write_o = cmd_i[0];
endmodule

// File: rtl/pci_tad_win_cmp.sv
module pci_tad_win_cmp
  import pci_tad_pkg::*;
#(
  parameter bit BYTE_EXACT = 1'b1
) (
  input  logic            en_i,
  input  logic [AD_W-1:0] addr_i,
  input  logic [AD_W-1:0] base_i,
  input  logic [AD_W-1:0] mask_i,
  output logic            hit_o
);
  logic [AD_W-1:0] keep;

  generate
    if (BYTE_EXACT) begin : g_byte
      assign keep = '1;
    end else begin : g_dword
      assign keep = {{(AD_W-DW_LSB){1'b1}}, {DW_LSB{1'b0}}};
    end
  endgenerate

  assign hit_o = en_i & win_hit(addr_i, base_i, mask_i, keep);
endmodule

// File: rtl/pci_tad_burst_ctr.sv
module pci_tad_burst_ctr
  import pci_tad_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [AD_W-1:0] load_val_i,
  input  logic            adv_i,
  output logic [AD_W-1:0] addr_o
);
  logic [AD_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      addr_q <= '0;
    else if (load_i) addr_q <= load_val_i;
    else if (adv_i)  addr_q <= burst_next(addr_q);
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/pci_tgt_addr_dec.sv
module pci_tgt_addr_dec
  import pci_tad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AD_W-1:0]   ad_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              frame_i,
  input  logic              irdy_i,
  input  logic              trdy_i,
  input  logic              mem_en_i,
  input  logic [AD_W-1:0]   mem_base_i,
  input  logic [AD_W-1:0]   mem_mask_i,
  input  logic              io_en_i,
  input  logic [AD_W-1:0]   io_base_i,
  input  logic [AD_W-1:0]   io_mask_i,
  output logic              claim_o,
  output logic              stop_o,
  output logic [1:0]        cyc_kind_o,
  output logic [AD_W-1:0]   loc_addr_o,
  output logic              loc_rd_o,
  output logic              loc_wr_o
);
  typedef enum logic {ST_IDLE = 1'b0, ST_DATA = 1'b1} st_e;

  st_e       st_q, st_d;
  logic      frame_q;
  cyc_kind_e kind_q, kind_now;
  logic      wr_q, wr_now;
  logic      unsup_q;
  logic      io_hit, mem_hit;

  // named internal events, also used by the checker
  logic      addr_cyc;   // first clock of a transaction
  logic      take_cyc;   // address cycle that this target claims
  logic      unsup_now;  // memory burst order other than linear
  logic      xfer;       // completed data phase
  logic      txn_end;    // last phase this target serves

  pci_tad_cmd_dec u_cmd (
    .cmd_i      (cmd_i),
    .kind_o     (kind_now),
    .is_write_o (wr_now)
  );

  pci_tad_win_cmp #(.BYTE_EXACT(1'b1)) u_io_win (
    .en_i   (io_en_i),
    .addr_i (ad_i),
    .base_i (io_base_i),
    .mask_i (io_mask_i),
    .hit_o  (io_hit)
  );

  pci_tad_win_cmp #(.BYTE_EXACT(1'b0)) u_mem_win (
    .en_i   (mem_en_i),
    .addr_i (ad_i),
    .base_i (mem_base_i),
    .mask_i (mem_mask_i),
    .hit_o  (mem_hit)
  );

  assign addr_cyc  = frame_i & ~frame_q & (st_q == ST_IDLE);
  assign take_cyc  = addr_cyc & (((kind_now == KIND_IO)  & io_hit) |
                                 ((kind_now == KIND_MEM) & mem_hit));
  assign unsup_now = (kind_now == KIND_MEM) & (ad_i[DW_LSB-1:0] != '0);
  assign xfer      = (st_q == ST_DATA) & irdy_i & trdy_i;
  assign txn_end   = xfer & (~frame_i | unsup_q);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (take_cyc) st_d = ST_DATA;
      ST_DATA: if (txn_end)  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      frame_q <= 1'b0;
      kind_q  <= KIND_SPECIAL;
      wr_q    <= 1'b0;
      unsup_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      frame_q <= frame_i;
      if (addr_cyc) begin
        kind_q  <= kind_now;
        wr_q    <= wr_now;
        unsup_q <= unsup_now;
      end
    end
  end

  pci_tad_burst_ctr u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (take_cyc),
    .load_val_i (first_addr(ad_i, kind_now == KIND_MEM)),
    .adv_i      (xfer & (kind_q == KIND_MEM)),
    .addr_o     (loc_addr_o)
  );

  assign claim_o    = (st_q == ST_DATA);
  assign stop_o     = (st_q == ST_DATA) & unsup_q;
  assign cyc_kind_o = kind_q;
  assign loc_rd_o   = xfer & ~wr_q;
  assign loc_wr_o   = xfer &  wr_q;
endmodule

// File: rtl/pci_tad_chk.sv
module pci_tad_chk
  import pci_tad_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            frame_i,
  input logic            irdy_i,
  input logic            trdy_i,
  input logic            claim_o,
  input logic            stop_o,
  input logic [1:0]      cyc_kind_o,
  input logic [AD_W-1:0] loc_addr_o,
  input logic            loc_rd_o,
  input logic            loc_wr_o,
  input logic            addr_cyc,
  input logic            xfer
);
  // R6: a claim only ever covers I/O or memory
  a_r6_claim_class: assert property (@(posedge clk) disable iff (!rst_n)
    claim_o |-> (cyc_kind_o == KIND_IO || cyc_kind_o == KIND_MEM));

  // R7: claim starts only right after an address cycle
  a_r7_claim_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(claim_o) |-> $past(addr_cyc));

  // R8: strobes need the claim and both ready qualifiers
  a_r8_strobe_qual: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_rd_o || loc_wr_o) |-> (claim_o && irdy_i && trdy_i));

  // R5: memory local address is dword aligned
  a_r5_mem_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_o && cyc_kind_o == KIND_MEM) |-> (loc_addr_o[DW_LSB-1:0] == '0));

  // R9: memory burst steps one dword per completed phase
  a_r9_mem_step: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_o && cyc_kind_o == KIND_MEM && xfer && frame_i && !stop_o)
      |=> (loc_addr_o == $past(loc_addr_o) + AD_W'(DW_BYTES)));

  // R4: I/O address is held across phases
  a_r4_io_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_o && cyc_kind_o == KIND_IO && xfer && frame_i) |=> $stable(loc_addr_o));

  // R10: final phase releases the claim
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !frame_i) |=> !claim_o);

  // R11: stop is only for a claimed memory cycle and ends after one phase
  a_r11_stop_mem: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> (claim_o && cyc_kind_o == KIND_MEM));
  a_r11_stop_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_o && xfer) |=> (!claim_o && !stop_o));
endmodule

bind pci_tgt_addr_dec pci_tad_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_i    (frame_i),
  .irdy_i     (irdy_i),
  .trdy_i     (trdy_i),
  .claim_o    (claim_o),
  .stop_o     (stop_o),
  .cyc_kind_o (cyc_kind_o),
  .loc_addr_o (loc_addr_o),
  .loc_rd_o   (loc_rd_o),
  .loc_wr_o   (loc_wr_o),
  .addr_cyc   (addr_cyc),
  .xfer       (xfer)
);

// File: tb/pci_tgt_addr_dec_tb.sv
module pci_tgt_addr_dec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  cmd = '0;
  logic        frame = 1'b0, irdy = 1'b0, trdy = 1'b0;
  logic        mem_en = 1'b1, io_en = 1'b1;
  logic [31:0] mem_base = 32'h8000_0000, mem_mask = 32'hFFF0_0000;
  logic [31:0] io_base  = 32'h0000_1000, io_mask  = 32'hFFFF_FF00;
  logic        claim, stop, rd, wr;
  logic [1:0]  kind;
  logic [31:0] laddr;

  int nchk = 0;
  int nbad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pci_tgt_addr_dec dut_i (
    .clk(clk), .rst_n(rst_n), .ad_i(ad), .cmd_i(cmd),
    .frame_i(frame), .irdy_i(irdy), .trdy_i(trdy),
    .mem_en_i(mem_en), .mem_base_i(mem_base), .mem_mask_i(mem_mask),
    .io_en_i(io_en), .io_base_i(io_base), .io_mask_i(io_mask),
    .claim_o(claim), .stop_o(stop), .cyc_kind_o(kind),
    .loc_addr_o(laddr), .loc_rd_o(rd), .loc_wr_o(wr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // class codes restated from the requirement text (R2)
  function automatic logic [1:0] exp_kind(input logic [3:0] c);
    if (c[3:1] == 3'b001) return 2'd1;
    if (c[3:1] == 3'b101) return 2'd3;
    if (c == 4'h6 || c == 4'h7 || c == 4'hC || c == 4'hE || c == 4'hF) return 2'd2;
    return 2'd0;
  endfunction

  function automatic bit exp_claim(input logic [3:0] c, input logic [31:0] a);
    logic [1:0] k;
    k = exp_kind(c);
    if (k == 2'd1) return io_en && (((a ^ io_base) & io_mask) == 32'h0);
    if (k == 2'd2) return mem_en && ((((a ^ mem_base) & mem_mask) >> 2) == 32'h0);
    return 1'b0;
  endfunction

  task automatic run_txn(input logic [3:0] c, input logic [31:0] a, input int nph);
    logic [1:0]  k;
    bit          cl, wdir, uns, last;
    logic [31:0] ea;
    int          done;
    k    = exp_kind(c);
    cl   = exp_claim(c, a);
    wdir = c[0];
    uns  = (k == 2'd2) && (a[1:0] != 2'b00);
    ea   = (k == 2'd2) ? {a[31:2], 2'b00} : a;
    @(negedge clk);
    frame = 1'b1; irdy = 1'b0; trdy = 1'b0; ad = a; cmd = c;
    @(negedge clk);
    ad = $urandom; cmd = 4'($urandom);   // R3: data-phase noise must not recapture
    #1;
    chk(kind == k, "R2 kind", 32'(kind), 32'(k));
    chk(claim == cl, "R7 claim after address cycle (R4/R5/R6)", 32'(claim), 32'(cl));
    chk(stop == (cl && uns), "R11 stop", 32'(stop), 32'(cl && uns));
    done = 0;
    while (done < nph) begin
      last  = (done == nph - 1);
      irdy  = ($urandom % 4) != 0;
      trdy  = ($urandom % 4) != 0;
      frame = !last;
      ad    = $urandom;
      #1;
      chk(claim == cl, "R7 claim held", 32'(claim), 32'(cl));
      chk(rd == (cl && irdy && trdy && !wdir), "R8 read strobe (R12)", 32'(rd),
          32'(cl && irdy && trdy && !wdir));
      chk(wr == (cl && irdy && trdy && wdir), "R8 write strobe (R12)", 32'(wr),
          32'(cl && irdy && trdy && wdir));
      if (cl) chk(laddr == ea, "R9 local address (R4/R5)", laddr, ea);
      @(posedge clk);
      if (irdy && trdy) begin
        done++;
        if (cl) begin
          if (k == 2'd2) ea = ea + 32'd4;
          if (uns || last) cl = 1'b0;
        end
      end
      @(negedge clk);
    end
    frame = 1'b0; irdy = 1'b0; trdy = 1'b0;
    #1;
    chk(claim == 1'b0, "R10 claim released", 32'(claim), 32'h0);
    chk(stop == 1'b0, "R11 stop released", 32'(stop), 32'h0);
  endtask

  function automatic logic [3:0] pick_cmd();
    logic [3:0] t[10] = '{4'h2, 4'h3, 4'h6, 4'h7, 4'hC, 4'hE, 4'hF, 4'hA, 4'h1, 4'h0};
    return t[$urandom % 10];
  endfunction

  initial begin
    logic [31:0] a;
    logic [3:0]  c;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    chk(claim == 0 && stop == 0 && rd == 0 && wr == 0, "R1 outputs idle in reset",
        {28'h0, claim, stop, rd, wr}, 32'h0);
    chk(kind == 2'd0, "R1 kind in reset", 32'(kind), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(claim == 0 && rd == 0 && wr == 0, "R1 idle after reset", {29'h0, claim, rd, wr}, 32'h0);

    // R2/R6: every command against both windows
    for (int i = 0; i < 16; i++) begin
      run_txn(4'(i), io_base + 32'h10, 2);
      run_txn(4'(i), mem_base + 32'h40, 2);
    end
    // R4: I/O byte exactness, an address one byte past the window misses
    run_txn(4'h2, io_base + 32'hFF, 2);
    run_txn(4'h3, io_base + 32'h100, 1);
    // R5: memory low bits ignored by compare; R11 unsupported order
    run_txn(4'h6, mem_base + 32'h11, 3);
    run_txn(4'h7, mem_base + 32'h22, 4);
    // disabled windows (R4/R5)
    io_en = 1'b0; mem_en = 1'b0;
    run_txn(4'h2, io_base, 2);
    run_txn(4'h6, mem_base, 2);
    io_en = 1'b1; mem_en = 1'b1;
    // R9: wrap of the burst counter at the top of the address space
    mem_base = 32'hFFF0_0000;
    run_txn(4'h6, 32'hFFFF_FFF8, 4);
    mem_base = 32'h8000_0000;

    // R3..R12 random mix
    for (int n = 0; n < 300; n++) begin
      c = pick_cmd();
      case ($urandom % 3)
        0: a = mem_base | ($urandom & ~mem_mask);
        1: a = io_base | ($urandom & ~io_mask);
        default: a = $urandom;
      endcase
      if (($urandom % 4) != 0) a[1:0] = 2'b00;
      run_txn(c, a, 1 + ($urandom % 5));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nbad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule